// File: doc/BRIEF.md
# Time-Aware Transmission Gate Scheduler

This block produces the open/closed state of each transmit queue's gate for scheduled traffic. Software fills one of two schedule banks with entries, each holding a gate mask, three flag bits and a duration in time-source ticks. It then writes an absolute 32-bit start time and issues an enable for that bank. On the clock edge where the running time equals the start time, the block begins walking the bank. Each entry's duration is added to find the next boundary.

While one bank runs, software can fill the other bank and arm a handover to it. The handover is triggered by the entry that starts exactly at a programmed change time. When that entry ends, the new bank's first entry follows. If the triggering entry carries an insert flag, the bank's last slot runs first. That slot is reserved for this purpose, and its interval is chosen to stretch or shorten the old cycle so that the new list starts on its exact boundary. A guard command opens a window of a fixed number of clock cycles. An enable that arrives after the window has expired is discarded, and the late condition is reported.

The register interface is a plain single-cycle write port; there is no data stream, so no valid/ready handshake applies. The time value comes from an external time source.

Top module: `tx_gate_sched`

## Requirements
- R1: After reset, and on the cycle after a disable command (control word 0, data bits [2:0] = 4), every gate output bit is 1 (open) and running_o is 0. A disable also cancels a pending start or handover.
- R2: The address is split into a region field `reg_addr[ADDR_W-1:WORD_W]` (0 = control, 1 = bank A, 2 = bank B) and a word field. Inside a bank, the slot is `reg_addr[WORD_W-1:1]`. The word select is `reg_addr[0]`: 0 holds the properties, 1 holds the interval. In the properties word, bits [NUM_GATES-1:0] are the gate mask, bit 16 is LAST, bit 17 is INSERT and bit 18 is CHANGE. Control word 0 is the command register, where data bits [2:0] are 1 = guard, 2 = enable A, 3 = enable B and 4 = disable. Control word 1 holds the start time and control word 2 holds the change time.
- R3: An accepted enable while idle arms a start. On the edge where time_i equals the start time, the gates take entry 0's mask of the selected bank, running_o rises, and bank_o shows that bank (0 = A, 1 = B).
- R4: A running entry holds its mask for exactly its interval. The gates change on the edge where time_i equals the entry's start plus its interval. An entry without LAST is followed by the next slot.
- R5: An entry with LAST is followed by entry 0 of the same bank.
- R6: An accepted enable while running arms a handover to the named bank. The entry that starts when time_i equals the change time runs to its end. If it has no INSERT flag, entry 0 of the named bank follows.
- R7: If the triggering entry has INSERT, the reserved slot (index SLOTS-1) of the running bank follows, with its own mask and interval. INSERT on an entry that did not trigger a handover has no effect.
- R8: When the reserved slot has CHANGE set, entry 0 of the named bank follows it as soon as its interval expires.
- R9: A guard command starts a window of GUARD_CYCLES clocks. If the window ends with no enable, timeout_o goes to 1. An enable received while timeout_o is 1 is discarded, and timeout_o returns to 0.
- R10: An enable received within the guard window is accepted, and timeout_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 32 | Low 32 bits of the running time |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| gate_o | output | NUM_GATES | Gate state per queue, 1 = open |
| running_o | output | 1 | A schedule is being executed |
| bank_o | output | 1 | Bank being executed, 0 = A, 1 = B |
| timeout_o | output | 1 | Late enable detected by the guard |

## Verification
The bench builds the block with NUM_GATES = 8, SLOTS = 4 and GUARD_CYCLES = 16. The four-slot banks put the reserved slot at index 3, so a two-entry list can be switched in both directions, with and without an inserted slot, within a few hundred ticks. The short guard window makes both a late enable and an in-window enable reachable in tens of cycles. The running time advances one tick per clock, so every expected mask follows from summing the programmed intervals.

// File: rtl/tgs_pkg.sv
package tgs_pkg;
  localparam int FLAG_LAST = 16;
  localparam int FLAG_INS  = 17;
  localparam int FLAG_CHG  = 18;

  localparam logic [1:0] REGION_CTRL = 2'd0;
  localparam logic [1:0] REGION_A    = 2'd1;
  localparam logic [1:0] REGION_B    = 2'd2;

  localparam int CW_CMD    = 0;
  localparam int CW_START  = 1;
  localparam int CW_CHANGE = 2;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_GUARD = 3'd1,
    CMD_EN_A  = 3'd2,
    CMD_EN_B  = 3'd3,
    CMD_OFF   = 3'd4
  } cmd_e;
endpackage

// File: rtl/tgs_bank.sv
module tgs_bank #(
  parameter int NUM_GATES = 8,
  parameter int SLOTS     = 8,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int EW       = NUM_GATES + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] slot_i,
  input  logic             word_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [EW-1:0]    rd_ent_o,
  output logic [31:0]      rd_iv_o
);
  import tgs_pkg::*;

  logic [EW-1:0] props_q [SLOTS];
  logic [31:0]   ivs_q   [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        props_q[i] <= '0;
        ivs_q[i]   <= '0;
      end
    end else if (we_i) begin
      if (word_i)
        ivs_q[slot_i] <= wdata_i;
      else
        props_q[slot_i] <= {wdata_i[FLAG_CHG], wdata_i[FLAG_INS],
                            wdata_i[FLAG_LAST], wdata_i[NUM_GATES-1:0]};
    end
  end

  assign rd_ent_o = props_q[rd_idx_i];
  assign rd_iv_o  = ivs_q[rd_idx_i];
endmodule

// File: rtl/tgs_guard.sv
module tgs_guard #(
  parameter int GUARD_CYCLES = 1024,
  localparam int CNT_W       = $clog2(GUARD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic en_i,
  output logic accept_o,
  output logic timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             on_q;
  logic             late_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      on_q   <= 1'b0;
      late_q <= 1'b0;
    end else if (arm_i) begin
      on_q  <= 1'b1;
      cnt_q <= CNT_W'(GUARD_CYCLES);
    end else if (en_i) begin
      on_q   <= 1'b0;
      late_q <= 1'b0;
    end else if (on_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        on_q   <= 1'b0;
        late_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign accept_o  = en_i && !late_q;
  assign timeout_o = late_q;

  AST_ENABLE_CLEARS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> !timeout_o); // R9
  AST_LATE_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(on_q)); // R9
endmodule

// File: rtl/tgs_seq.sv
module tgs_seq #(
  parameter int NUM_GATES = 8,
  parameter int SLOTS     = 8,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam logic [IDX_W-1:0] RES = IDX_W'(SLOTS - 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          time_i,
  input  logic [31:0]          start_t_i,
  input  logic [31:0]          change_t_i,
  input  logic                 en_i,
  input  logic                 en_bank_i,
  input  logic                 off_i,
  input  logic [NUM_GATES-1:0] ent_mask_i,
  input  logic                 ent_last_i,
  input  logic                 ent_ins_i,
  input  logic                 ent_chg_i,
  input  logic [31:0]          ent_iv_i,
  output logic                 rd_bank_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic [NUM_GATES-1:0] gate_o,
  output logic                 run_o,
  output logic                 bank_o
);
  logic                 run_q, bank_q, target_q;
  logic                 arm_start_q, arm_chg_q, trig_q;
  logic                 fl_last_q, fl_ins_q, fl_chg_q;
  logic [IDX_W-1:0]     idx_q;
  logic [31:0]          bound_q;
  logic [NUM_GATES-1:0] gate_q;
  logic                 nb;
  logic [IDX_W-1:0]     ni;
  logic                 start_hit, bound_hit, chg_hit;

  // choice of the entry that follows the current one
  always_comb begin
    nb = bank_q;
    ni = IDX_W'(idx_q + 1'b1);
    if (!run_q) begin
      nb = target_q;
      ni = '0;
    end else if (idx_q == RES && fl_chg_q) begin
      nb = target_q;
      ni = '0;
    end else if (trig_q && fl_ins_q) begin
      ni = RES;
    end else if (trig_q) begin
      nb = target_q;
      ni = '0;
    end else if (fl_last_q) begin
      ni = '0;
    end
  end

  assign start_hit = !run_q && arm_start_q && (time_i == start_t_i);
  assign bound_hit = run_q && (time_i == bound_q);
  assign chg_hit   = arm_chg_q && (time_i == change_t_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; bank_q <= 1'b0; target_q <= 1'b0;
      arm_start_q <= 1'b0; arm_chg_q <= 1'b0; trig_q <= 1'b0;
      fl_last_q <= 1'b0; fl_ins_q <= 1'b0; fl_chg_q <= 1'b0;
      idx_q <= '0; bound_q <= '0; gate_q <= '1;
    end else if (off_i) begin
      run_q <= 1'b0; arm_start_q <= 1'b0; arm_chg_q <= 1'b0;
      trig_q <= 1'b0; gate_q <= '1;
    end else begin
      if (en_i) begin
        target_q <= en_bank_i;
        if (run_q) arm_chg_q <= 1'b1;
        else       arm_start_q <= 1'b1;
      end
      if (start_hit || bound_hit) begin
        bank_q    <= nb;
        idx_q     <= ni;
        gate_q    <= ent_mask_i;
        bound_q   <= time_i + ent_iv_i;
        fl_last_q <= ent_last_i;
        fl_ins_q  <= ent_ins_i;
        fl_chg_q  <= ent_chg_i;
      end
      if (start_hit) begin
        run_q       <= 1'b1;
        arm_start_q <= 1'b0;
        trig_q      <= 1'b0;
      end else if (bound_hit) begin
        trig_q <= chg_hit;
        if (chg_hit) arm_chg_q <= 1'b0;
      end
    end
  end

  assign rd_bank_o = nb;
  assign rd_idx_o  = ni;
  assign gate_o    = gate_q;
  assign run_o     = run_q;
  assign bank_o    = bank_q;

  AST_IDLE_GATES_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (gate_q == '1)); // R1
  AST_OFF_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    off_i |=> (!run_q && gate_q == '1)); // R1
  AST_START_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ($past(time_i) == $past(start_t_i))); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && time_i != bound_q && !off_i) |=> $stable(gate_q)); // R4
endmodule

// File: rtl/tx_gate_sched.sv
module tx_gate_sched #(
  parameter int NUM_GATES    = 8,
  parameter int SLOTS        = 8,
  parameter int GUARD_CYCLES = 1024,
  localparam int WORD_W      = $clog2(2 * SLOTS),
  localparam int ADDR_W      = WORD_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          time_i,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [NUM_GATES-1:0] gate_o,
  output logic                 running_o,
  output logic                 bank_o,
  output logic                 timeout_o
);
  import tgs_pkg::*;

  localparam int IDX_W = $clog2(SLOTS);
  localparam int EW    = NUM_GATES + 3;

  logic [1:0]        region;
  logic [WORD_W-1:0] word;
  logic              ctl_we, cmd_we;
  cmd_e              cmd;
  logic              arm_guard, en_req, en_ok, off_cmd;
  logic [31:0]       start_t_q, change_t_q;
  logic              rd_bank;
  logic [IDX_W-1:0]  rd_idx;
  logic [EW-1:0]     ent_arr [2];
  logic [31:0]       iv_arr  [2];
  logic [EW-1:0]     ent;

  assign region    = reg_addr[ADDR_W-1:WORD_W];
  assign word      = reg_addr[WORD_W-1:0];
  assign ctl_we    = reg_we && (region == REGION_CTRL);
  assign cmd_we    = ctl_we && (word == WORD_W'(CW_CMD));
  assign cmd       = cmd_e'(reg_wdata[2:0]);
  assign arm_guard = cmd_we && (cmd == CMD_GUARD);
  assign en_req    = cmd_we && (cmd == CMD_EN_A || cmd == CMD_EN_B);
  assign off_cmd   = cmd_we && (cmd == CMD_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_t_q  <= '0;
      change_t_q <= '0;
    end else if (ctl_we) begin
      if (word == WORD_W'(CW_START))  start_t_q  <= reg_wdata;
      if (word == WORD_W'(CW_CHANGE)) change_t_q <= reg_wdata;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    tgs_bank #(.NUM_GATES(NUM_GATES), .SLOTS(SLOTS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (reg_we && region == ((b == 0) ? REGION_A : REGION_B)),
      .slot_i  (reg_addr[WORD_W-1:1]),
      .word_i  (reg_addr[0]),
      .wdata_i (reg_wdata),
      .rd_idx_i(rd_idx),
      .rd_ent_o(ent_arr[b]),
      .rd_iv_o (iv_arr[b])
    );
  end

  assign ent = ent_arr[rd_bank];

  tgs_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_guard),
    .en_i     (en_req),
    .accept_o (en_ok),
    .timeout_o(timeout_o)
  );

  tgs_seq #(.NUM_GATES(NUM_GATES), .SLOTS(SLOTS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .time_i    (time_i),
    .start_t_i (start_t_q),
    .change_t_i(change_t_q),
    .en_i      (en_ok),
    .en_bank_i (cmd == CMD_EN_B),
    .off_i     (off_cmd),
    .ent_mask_i(ent[NUM_GATES-1:0]),
    .ent_last_i(ent[NUM_GATES]),
    .ent_ins_i (ent[NUM_GATES+1]),
    .ent_chg_i (ent[NUM_GATES+2]),
    .ent_iv_i  (iv_arr[rd_bank]),
    .rd_bank_o (rd_bank),
    .rd_idx_o  (rd_idx),
    .gate_o    (gate_o),
    .run_o     (running_o),
    .bank_o    (bank_o)
  );
endmodule

// File: tb/tx_gate_sched_test.sv
module tx_gate_sched_test;
  localparam int NG = 8, SL = 4, GC = 16;
  localparam int AW = $clog2(2 * SL) + 2;
  localparam int BA = 8, BB = 16;
  localparam logic [31:0] LAST = 32'h1 << 16, INS = 32'h1 << 17, CHG = 32'h1 << 18;
  localparam int NV = 20;
  // {time, expected gates, expected bank, requirement}
  localparam logic [63:0] VEC [NV] = '{
    {32'd150, 8'hFF, 8'd0, 16'd1},  // R1 idle before start
    {32'd199, 8'hFF, 8'd0, 16'd3},  // R3
    {32'd200, 8'h01, 8'd0, 16'd3},  // R3 start edge
    {32'd209, 8'h01, 8'd0, 16'd4},  // R4
    {32'd210, 8'h06, 8'd0, 16'd4},  // R4
    {32'd229, 8'h06, 8'd0, 16'd4},  // R4
    {32'd230, 8'h01, 8'd0, 16'd5},  // R5 wrap
    {32'd240, 8'h06, 8'd0, 16'd5},  // R5
    {32'd299, 8'h01, 8'd0, 16'd5},  // R5
    {32'd319, 8'h06, 8'd0, 16'd6},  // R6 triggering entry
    {32'd320, 8'h10, 8'd1, 16'd6},  // R6 handover
    {32'd335, 8'h20, 8'd1, 16'd6},  // R6
    {32'd350, 8'h10, 8'd1, 16'd6},  // R6
    {32'd365, 8'h20, 8'd1, 16'd7},  // R7 untriggered INSERT ignored
    {32'd424, 8'h10, 8'd1, 16'd7},  // R7
    {32'd425, 8'h80, 8'd1, 16'd7},  // R7 reserved slot
    {32'd431, 8'h80, 8'd1, 16'd8},  // R8
    {32'd432, 8'h01, 8'd0, 16'd8},  // R8 CHANGE to bank A
    {32'd442, 8'h06, 8'd0, 16'd8},  // R8
    {32'd462, 8'h01, 8'd0, 16'd8}   // R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] sys_time = '0;
  logic reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [NG-1:0] gate_o;
  logic running_o, bank_o, timeout_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  tx_gate_sched #(.NUM_GATES(NG), .SLOTS(SL), .GUARD_CYCLES(GC)) uut (
    .clk(clk), .rst_n(rst_n), .time_i(sys_time), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .gate_o(gate_o),
    .running_o(running_o), .bank_o(bank_o), .timeout_o(timeout_o));

  always #2 clk = ~clk;
  always @(posedge clk) sys_time <= sys_time + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0d", req, act, exp, sys_time);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_t(input logic [31:0] t);
    while (sys_time < t) @(negedge clk);
  endtask

  // gates for time t are visible once the time has moved to t+1
  task automatic at(input logic [31:0] t);
    wait_t(t + 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    chk("R1 reset gates", 32'(gate_o), 32'hFF);
    chk("R1 reset running", 32'(running_o), 0);
    chk("R1 reset timeout", 32'(timeout_o), 0);
    rst_n = 1'b1;
    fork
      begin
        wr(BA + 0, 32'h01);        wr(BA + 1, 10);        // R2 field layout
        wr(BA + 2, 32'h06 | LAST); wr(BA + 3, 20);
        wr(BB + 0, 32'h10 | INS);  wr(BB + 1, 15);
        wr(BB + 2, 32'h20 | LAST); wr(BB + 3, 15);
        wr(BB + 6, 32'h80 | CHG);  wr(BB + 7, 7);
        wr(1, 200); wr(0, 2);
        wait_t(250); wr(2, 300); wr(0, 3);
        wait_t(390); wr(2, 410); wr(0, 2);
      end
      begin
        for (int i = 0; i < NV; i++) begin
          at(VEC[i][63:32]);
          chk($sformatf("R%0d gates", VEC[i][15:0]), 32'(gate_o), 32'(VEC[i][31:24]));
          chk($sformatf("R%0d bank", VEC[i][15:0]), 32'(bank_o), 32'(VEC[i][23:16]));
        end
      end
    join
    chk("R3 running", 32'(running_o), 1);
    // R1 disable while running
    wr(0, 4);
    chk("R1 off gates", 32'(gate_o), 32'hFF);
    chk("R1 off running", 32'(running_o), 0);
    // R9 late enable discarded
    wr(0, 1);
    repeat (GC + 4) @(negedge clk);
    chk("R9 timeout set", 32'(timeout_o), 1);
    s = sys_time + 40;
    wr(1, s); wr(0, 2);
    chk("R9 timeout cleared", 32'(timeout_o), 0);
    at(s + 5);
    chk("R9 discarded gates", 32'(gate_o), 32'hFF);
    chk("R9 discarded running", 32'(running_o), 0);
    // R10 enable inside window
    s = sys_time + 40;
    wr(1, s); wr(0, 1); wr(0, 2);
    chk("R10 no timeout", 32'(timeout_o), 0);
    at(s);
    chk("R10 started gates", 32'(gate_o), 32'h01);
    chk("R10 running", 32'(running_o), 1);
    // R1 disable cancels an armed start
    wr(0, 4);
    s = sys_time + 30;
    wr(1, s); wr(0, 3); wr(0, 4);
    at(s + 3);
    chk("R1 cancelled gates", 32'(gate_o), 32'hFF);
    chk("R1 cancelled running", 32'(running_o), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule